// File: doc/BRIEF.md
# Resolver Converter Readout Controller

This block reads angle or angular velocity from an external resolver-to-digital converter. It has a request input, a select input and a receive-only serial link. When a request is accepted, the block pulls the converter's sample strobe low for a set number of system clocks and then releases it. It drives the data-select line high for an angle read and low for a velocity read. It then clocks in one 16-bit word with chip select held low, using a clock that idles high and is sampled on its rising edge (SPI mode 3).

The twelve most significant bits of the received word are the result. The block zero-extends them for an angle read and sign-extends them for a velocity read. It presents the 16-bit result with a single-cycle valid pulse. It keeps busy high through a recovery interval before it will accept the next request. The host gives the system clock frequency in MHz and the half-period of the serial clock in system clocks. From these the block derives the strobe width and the recovery time, each as a whole number of serial periods plus 20 ns, rounded up to system clocks.

Top module: `rdc_readout`

## Requirements
- R1: After reset, `sample_o` is 0, `rdsel_o` is 0, `busy_o` is 0, `valid_o` is 0, `spi_cs_n_o` is 1 and `spi_sclk_o` is 1.
- R2: On the clock edge that accepts a request, `sample_o` goes to 0. It stays 0 for exactly STROBE_CYC = 12*SCLK_HALF + ceil(20*SYS_CLK_MHZ/1000) cycles, then returns to 1 and stays 1 until the next accepted request.
- R3: On the accepting edge, `rdsel_o` takes the value of `sel_angle_i` (1 = angle, 0 = velocity). It holds that value until the next accepted request, so it is settled before chip select falls.
- R4: `spi_cs_n_o` goes low on the same edge that `sample_o` returns high. It stays low for 32*SCLK_HALF cycles. `spi_sclk_o` is 1 whenever chip select is high.
- R5: During the transfer, `spi_sclk_o` makes 16 periods. Each period is SCLK_HALF cycles low followed by SCLK_HALF cycles high, and the first low phase starts SCLK_HALF cycles after chip select falls.
- R6: `spi_miso_i` is captured on each rising edge of `spi_sclk_o`, most significant bit first. Bits 15..4 of the received word form the 12-bit field, and bits 3..0 are dropped.
- R7: For an angle read, `data_o` = {4'b0000, field}. For a velocity read, `data_o` = the field sign-extended from its bit 11 to 16 bits.
- R8: `valid_o` is high for exactly one cycle, the cycle after `spi_cs_n_o` returns high. `data_o` carries the result in that cycle.
- R9: `busy_o` rises on the accepting edge. It falls RECOV_CYC = 4*SCLK_HALF + ceil(20*SYS_CLK_MHZ/1000) cycles after the edge that raised `valid_o`.
- R10: A request made while `busy_o` is 1 is ignored: it changes no output and starts no read. A request held high is accepted again only once busy has dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 1 | Read request, sampled when not busy |
| sel_angle_i | input | 1 | 1 reads angle, 0 reads velocity |
| busy_o | output | 1 | High from acceptance through recovery |
| valid_o | output | 1 | One-cycle result strobe |
| data_o | output | OUT_W | Formatted result |
| sample_o | output | 1 | Converter sample strobe, active-low pulse |
| rdsel_o | output | 1 | Converter data select, high for angle |
| spi_sclk_o | output | 1 | Serial clock, idles high |
| spi_cs_n_o | output | 1 | Chip select, active low |
| spi_miso_i | input | 1 | Serial data from the converter |

## Verification
The bound checker watches the invariants that hold on every cycle. It checks that the serial clock is high whenever chip select is high and that chip select is low only after the strobe has been released. It checks that the select line stays fixed while busy and that valid is a single-cycle pulse that never appears outside a busy interval. It also checks that a strobe can fall only on an accepting edge. The exact strobe width, the clock phase count, the bit order, the extension of the field for each read type and the length of the recovery interval depend on the data and the counts. The bench's cycle-accurate reference model shows these. It is run with a behavioural converter against boundary words (full scale, most negative and most positive velocity, all-ones) and with requests made while busy or held high.

// File: rtl/rdc_pkg.sv
package rdc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_STROBE = 2'd1,
    ST_XFER   = 2'd2,
    ST_RECOV  = 2'd3
  } rdc_state_e;

  // cycles needed to cover a delay in ns, rounded up
  function automatic int ns_to_cycles(input int ns, input int clk_mhz);
    return (ns * clk_mhz + 999) / 1000;
  endfunction

endpackage

// File: rtl/rdc_hold_timer.sv
module rdc_hold_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (load) begin
      cnt_q <= load_val;
      run_q <= 1'b1;
    end else if (run_q) begin
      if (cnt_q == '0) run_q <= 1'b0;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = run_q && (cnt_q == '0);
endmodule

// File: rtl/rdc_spi_rx.sv
module rdc_spi_rx #(
  parameter int FRAME_W   = 16,
  parameter int FIELD_W   = 12,
  parameter int SCLK_HALF = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               miso,
  output logic               sclk,
  output logic               cs_n,
  output logic               done,
  output logic [FIELD_W-1:0] field
);
  localparam int HC_W  = (SCLK_HALF < 2) ? 1 : $clog2(SCLK_HALF);
  localparam int EDGES = 2 * FRAME_W;
  localparam int EC_W  = $clog2(EDGES + 1);

  logic               active_q;
  logic [HC_W-1:0]    half_q;
  logic [EC_W-1:0]    edge_q;
  logic [FRAME_W-1:0] shreg_q;
  logic               tick;

  assign tick = active_q && (half_q == HC_W'(SCLK_HALF - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      half_q   <= '0;
      edge_q   <= '0;
      shreg_q  <= '0;
      sclk     <= 1'b1;
      cs_n     <= 1'b1;
      done     <= 1'b0;
    end else if (start) begin
      active_q <= 1'b1;
      half_q   <= '0;
      edge_q   <= '0;
      sclk     <= 1'b1;
      cs_n     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (active_q) begin
        if (tick) begin
          half_q <= '0;
          edge_q <= edge_q + 1'b1;
          if (!edge_q[0]) begin
            sclk <= 1'b0;
          end else begin
            sclk    <= 1'b1;
            shreg_q <= {shreg_q[FRAME_W-2:0], miso};
          end
          if (edge_q == EC_W'(EDGES - 1)) begin
            active_q <= 1'b0;
            cs_n     <= 1'b1;
            done     <= 1'b1;
          end
        end else begin
          half_q <= half_q + 1'b1;
        end
      end
    end
  end

  assign field = shreg_q[FRAME_W-1 -: FIELD_W];
endmodule

// File: rtl/rdc_formatter.sv
module rdc_formatter #(
  parameter int FIELD_W = 12,
  parameter int OUT_W   = 16
) (
  input  logic [FIELD_W-1:0] field,
  input  logic               is_angle,
  output logic [OUT_W-1:0]   result
);
  localparam int PAD_W = OUT_W - FIELD_W;

  generate
    if (PAD_W > 0) begin : g_pad
      logic pad_bit;
      assign pad_bit = is_angle ? 1'b0 : field[FIELD_W-1];
      assign result  = {{PAD_W{pad_bit}}, field};
    end else begin : g_nopad
      assign result = field[OUT_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/rdc_readout.sv
module rdc_readout #(
  parameter int SYS_CLK_MHZ = 100,
  parameter int SCLK_HALF   = 7,
  parameter int FRAME_W     = 16,
  parameter int FIELD_W     = 12,
  parameter int OUT_W       = 16,
  parameter int GUARD_NS    = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic             sel_angle_i,
  output logic             busy_o,
  output logic             valid_o,
  output logic [OUT_W-1:0] data_o,
  output logic             sample_o,
  output logic             rdsel_o,
  output logic             spi_sclk_o,
  output logic             spi_cs_n_o,
  input  logic             spi_miso_i
);
  import rdc_pkg::*;

  localparam int GUARD_CYC  = ns_to_cycles(GUARD_NS, SYS_CLK_MHZ);
  localparam int STROBE_CYC = 6 * 2 * SCLK_HALF + GUARD_CYC;
  localparam int RECOV_CYC  = 2 * 2 * SCLK_HALF + GUARD_CYC;
  localparam int TMR_W      = $clog2(STROBE_CYC + 1) + 1;

  rdc_state_e         state_q;
  logic               strobe_load, strobe_exp;
  logic               recov_load, recov_exp;
  logic               spi_start, spi_done;
  logic [FIELD_W-1:0] spi_field;
  logic [OUT_W-1:0]   fmt_result;

  assign strobe_load = (state_q == ST_IDLE) && req_i;
  assign spi_start   = (state_q == ST_STROBE) && strobe_exp;
  assign recov_load  = (state_q == ST_XFER) && spi_done;

  rdc_hold_timer #(.CNT_W(TMR_W)) i_strobe_tmr (
    .clk(clk), .rst(rst), .load(strobe_load),
    .load_val(TMR_W'(STROBE_CYC - 1)), .expired(strobe_exp)
  );

  rdc_hold_timer #(.CNT_W(TMR_W)) i_recov_tmr (
    .clk(clk), .rst(rst), .load(recov_load),
    .load_val(TMR_W'(RECOV_CYC - 1)), .expired(recov_exp)
  );

  rdc_spi_rx #(.FRAME_W(FRAME_W), .FIELD_W(FIELD_W), .SCLK_HALF(SCLK_HALF)) i_spi (
    .clk(clk), .rst(rst), .start(spi_start), .miso(spi_miso_i),
    .sclk(spi_sclk_o), .cs_n(spi_cs_n_o), .done(spi_done), .field(spi_field)
  );

  rdc_formatter #(.FIELD_W(FIELD_W), .OUT_W(OUT_W)) i_fmt (
    .field(spi_field), .is_angle(rdsel_o), .result(fmt_result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      busy_o   <= 1'b0;
      valid_o  <= 1'b0;
      data_o   <= '0;
      sample_o <= 1'b0;
      rdsel_o  <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          state_q  <= ST_STROBE;
          busy_o   <= 1'b1;
          sample_o <= 1'b0;
          rdsel_o  <= sel_angle_i;
        end
        ST_STROBE: if (strobe_exp) begin
          sample_o <= 1'b1;
          state_q  <= ST_XFER;
        end
        ST_XFER: if (spi_done) begin
          valid_o <= 1'b1;
          data_o  <= fmt_result;
          state_q <= ST_RECOV;
        end
        ST_RECOV: if (recov_exp) begin
          busy_o  <= 1'b0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rdc_readout_checker.sv
module rdc_readout_checker (
  input logic clk,
  input logic rst,
  input logic busy_o,
  input logic valid_o,
  input logic sample_o,
  input logic rdsel_o,
  input logic spi_sclk_o,
  input logic spi_cs_n_o
);
  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n_o |-> spi_sclk_o);

  assert_cs_after_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    !spi_cs_n_o |-> (sample_o && busy_o));

  assert_strobe_fall_accept_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(sample_o) |-> (busy_o && !$past(busy_o)));

  assert_rdsel_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (busy_o && $past(busy_o)) |-> $stable(rdsel_o));

  assert_valid_single_R8: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);

  assert_valid_in_busy_R9: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> (busy_o && spi_cs_n_o));

  assert_no_cs_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> spi_cs_n_o);
endmodule

bind rdc_readout rdc_readout_checker i_rdc_chk (
  .clk(clk), .rst(rst), .busy_o(busy_o), .valid_o(valid_o),
  .sample_o(sample_o), .rdsel_o(rdsel_o),
  .spi_sclk_o(spi_sclk_o), .spi_cs_n_o(spi_cs_n_o)
);

// File: tb/test_rdc_readout.sv
module test_rdc_readout;
  localparam int CLK_PERIOD = 10;
  localparam int MHZ  = 100;
  localparam int H    = 2;
  localparam int G    = (20 * MHZ + 999) / 1000;
  localparam int S    = 12 * H + G;
  localparam int R    = 4 * H + G;
  localparam int XEND = S + 32 * H;
  localparam int VT   = XEND + 1;
  localparam int ENDT = VT + R;

  logic clk = 1'b0, rst = 1'b1, req = 1'b0, sel = 1'b0, miso = 1'b0;
  logic busy, valid, sample, rdsel, sclk, cs_n;
  logic [15:0] data;

  int tests = 0, fails = 0, cyc = 0, t = -1, idx = 0, valid_seen = 0;
  logic started = 1'b0;
  logic e_sample = 1'b0, e_rdsel = 1'b0;
  logic [15:0] slave_word = 16'h0, cur_word = 16'h0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rdc_readout #(.SYS_CLK_MHZ(MHZ), .SCLK_HALF(H)) i_rdc_readout (
    .clk(clk), .rst(rst), .req_i(req), .sel_angle_i(sel), .busy_o(busy),
    .valid_o(valid), .data_o(data), .sample_o(sample), .rdsel_o(rdsel),
    .spi_sclk_o(sclk), .spi_cs_n_o(cs_n), .spi_miso_i(miso)
  );

  // behavioural converter: new bit on each falling serial clock
  always @(negedge cs_n) idx = 0;
  always @(negedge sclk) begin
    miso = slave_word[15 - idx];
    idx  = idx + 1;
  end

  function automatic logic [15:0] expect_word(input logic [15:0] w, input logic ang);
    return ang ? {4'h0, w[15:4]} : {{4{w[15]}}, w[15:4]};
  endfunction

  task automatic check(input logic ok, input string rq, input logic [15:0] act,
                       input logic [15:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", rq, cyc, act, exp);
    end
  endtask

  // reference model, advanced on every edge
  always @(posedge clk) begin
    cyc++;
    started <= 1'b1;
    if (rst) begin
      t = -1; e_sample = 1'b0; e_rdsel = 1'b0;
    end else begin
      if (t < 0) begin
        if (req) begin t = 0; e_rdsel = sel; cur_word = slave_word; end
      end else begin
        t = t + 1;
        if (t == ENDT) t = -1;
      end
      if (t >= 0) e_sample = (t >= S);
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (started) begin
      logic e_cs_n, e_sclk, e_busy, e_valid;
      e_busy  = (t >= 0);
      e_cs_n  = !(t >= S && t < XEND);
      e_sclk  = (t >= S && t < XEND) ? (((t - S) / H) % 2 == 0) : 1'b1;
      e_valid = (t == VT);
      check(busy == e_busy, "R9/R10 busy", 16'(busy), 16'(e_busy));
      check(sample == e_sample, "R2 sample", 16'(sample), 16'(e_sample));
      check(rdsel == e_rdsel, "R3 rdsel", 16'(rdsel), 16'(e_rdsel));
      check(cs_n == e_cs_n, "R4 cs_n", 16'(cs_n), 16'(e_cs_n));
      check(sclk == e_sclk, "R5 sclk", 16'(sclk), 16'(e_sclk));
      check(valid == e_valid, "R8 valid", 16'(valid), 16'(e_valid));
      if (e_valid)
        check(data == expect_word(cur_word, e_rdsel), "R6/R7 data", data,
              expect_word(cur_word, e_rdsel));
      if (valid) valid_seen++;
    end
  end

  task automatic do_read(input logic ang, input logic [15:0] w);
    @(negedge clk);
    slave_word = w; sel = ang; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    while (busy) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state, checked explicitly
    check(!sample && !rdsel && !busy && !valid && cs_n && sclk, "R1 reset",
          {10'h0, sample, rdsel, busy, valid, cs_n, sclk}, 16'h0003);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    do_read(1'b1, 16'hABCD);   // R7 angle zero-extended -> 0ABC
    do_read(1'b0, 16'hABCD);   // R7 velocity negative -> FABC
    do_read(1'b0, 16'h7FF0);   // R7 most positive velocity -> 07FF
    do_read(1'b0, 16'h8000);   // R7 most negative velocity -> F800
    do_read(1'b1, 16'hFFFF);   // R6 full-scale angle -> 0FFF
    do_read(1'b0, 16'hFFFF);   // R7 velocity -1 -> FFFF
    do_read(1'b1, 16'h000F);   // R6 low nibble dropped -> 0000
    do_read(1'b0, 16'h1230);   // R6 MSB-first order -> 0123
    // R10: requests while busy are ignored
    @(negedge clk);
    slave_word = 16'h5550; sel = 1'b1; req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    repeat (10) @(negedge clk);
    sel = 1'b0; req = 1'b1;
    @(negedge clk);
    req = 1'b0; sel = 1'b1;
    repeat (S + 10) @(negedge clk);
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    while (busy) @(negedge clk);
    check(rdsel == 1'b1, "R10 rdsel kept", 16'(rdsel), 16'h1);
    // R10: request held high gives exactly two reads in two windows
    valid_seen = 0;
    @(negedge clk);
    slave_word = 16'h3C30; sel = 1'b0; req = 1'b1;
    repeat (2 * (ENDT + 1)) @(negedge clk);
    req = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    check(valid_seen == 2, "R10 held request", 16'(valid_seen), 16'd2);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule